// File: doc/BRIEF.md
# Write-Read Order Protection Unit

This block sits between the data-access stage of a pipelined processor and a single memory bus. The pipeline hands it a write channel and a read channel. Writes go into a one-entry pending buffer and reach the bus one cycle or more after they are accepted. Reads go to the bus in the cycle they are presented. An ordinary read therefore overtakes an older write that is still pending, which is the normal pipeline behaviour.

When either access of such a pair lies inside an enabled protected zone, the unit keeps program order. It holds the read and raises `stall` until the older write has been accepted by the bus. The extra cycles are the cost of keeping that order. A read to the same address as a pending write is also held, so it can never return stale data. The protected zones are the two slower peripheral frames. Each zone is an inclusive base and limit address window set by parameters, and each has an enable bit that can be changed at run time. All peripheral frames are reachable only as data space. A program-space access whose address falls in the peripheral range is consumed silently and never reaches the bus.

The pipeline protocol is simple. While `stall` is high, the pipeline keeps both request channels unchanged. An access counts as taken in any cycle where its valid is high and `stall` is low. The bus accepts the request shown in a cycle when `busReady` is high.

Top module: `wro_top`

## Requirements
- R1: While and right after reset, `stall` and `busValid` are 0, and both protection zones are enabled (zone 0 = 0x6000..0x6FFF, zone 1 = 0x7000..0x7FFF).
- R2: A taken data write appears on the bus with `busWrite`=1 and its address and data, at the earliest in the cycle after it was taken. It stays on the bus unchanged until `busReady` is high. Writes reach the bus in the order they were taken.
- R3: A read that is not held is driven on the bus (`busWrite`=0) in the cycle it is presented, ahead of any older pending write. With `busReady` high it causes no stall.
- R4: If the read or the older write (pending, or presented in the same cycle) lies in an enabled zone, the read is issued only after that write has been accepted. With `busReady` high this costs 1 stall cycle when the write is already pending, and 2 when the write arrives in the same cycle as the read.
- R5: A read whose address equals that of an older pending write is held in the same way as in R4, even when it lies outside the zones.
- R6: A program-space read or write (prog flag = 1) to an address in the peripheral range 0x0800..0x7FFF produces no bus request and no stall. Program-space accesses outside that range are forwarded like data accesses.
- R7: When `cfgWe` is high, `cfgProt` is loaded into the zone enables (bit z = zone z). A disabled zone no longer causes reads to be held.
- R8: A write presented while the buffer is full and not draining raises `stall` until the buffer drains. The new write is then taken in the draining cycle.
- R9: A read on the bus that is not accepted (`busReady`=0) keeps `stall` high until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Load zone enables |
| cfgProt | input | NZONE | New zone enable bits |
| wrValid | input | 1 | Write request valid |
| wrAddr | input | AW | Write address |
| wrData | input | DW | Write data |
| wrProg | input | 1 | Write targets program space |
| rdValid | input | 1 | Read request valid |
| rdAddr | input | AW | Read address |
| rdProg | input | 1 | Read targets program space |
| busReady | input | 1 | Bus accepts current request |
| busValid | output | 1 | Bus request valid |
| busWrite | output | 1 | Bus request is a write |
| busAddr | output | AW | Bus address |
| busWData | output | DW | Bus write data |
| stall | output | 1 | Hold the pipeline's request channels |

## Verification
Two functions can fall in the same cycle: a write being captured into the pending buffer, and a read that must decide whether to overtake it. The bench provokes this by presenting a write and a read together. It uses the same pair once with plain addresses, where the read must come first on the bus, and once with a protected read, where the write must come first after two stall cycles. A scoreboard queue holds the expected bus order for each case. The stall count is compared with the cycle count stated in R4.

// File: rtl/wro_pkg.sv
package wro_pkg;
  typedef struct packed {
    logic capWr;
    logic selRd;
  } ctlStrobe_t;

  typedef struct packed {
    logic rdFrame;
    logic wrFrame;
    logic rdProt;
    logic wrProt;
    logic pendProt;
    logic pendHitRd;
    logic wrHitRd;
  } dpFlags_t;
endpackage

// File: rtl/wro_datapath.sv
module wro_datapath
  import wro_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int NZONE = 2,
  parameter logic [AW-1:0] FRAME_BASE = 16'h0800,
  parameter logic [AW-1:0] FRAME_LIMIT = 16'h7FFF,
  parameter logic [NZONE*AW-1:0] ZONE_BASE = {16'h7000, 16'h6000},
  parameter logic [NZONE*AW-1:0] ZONE_LIMIT = {16'h7FFF, 16'h6FFF}
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [NZONE-1:0] cfgProt,
  input  logic [AW-1:0]    wrAddr,
  input  logic [DW-1:0]    wrData,
  input  logic [AW-1:0]    rdAddr,
  input  ctlStrobe_t       strobe,
  output dpFlags_t         flags,
  output logic [NZONE-1:0] protEn,
  output logic [AW-1:0]    busAddr,
  output logic [DW-1:0]    busWData
);
  logic [NZONE-1:0] protEnR;
  logic [AW-1:0]    pendAddr;
  logic [DW-1:0]    pendData;
  logic             pendProtR;
  logic [NZONE-1:0] rdZone, wrZone;

  always_ff @(posedge clk) begin
    if (!rstN) protEnR <= '1;
    else if (cfgWe) protEnR <= cfgProt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendAddr  <= '0;
      pendData  <= '0;
      pendProtR <= 1'b0;
    end else if (strobe.capWr) begin
      pendAddr  <= wrAddr;
      pendData  <= wrData;
      pendProtR <= flags.wrProt;
    end
  end

  for (genvar z = 0; z < NZONE; z++) begin : g_zone
    localparam logic [AW-1:0] ZB = ZONE_BASE[z*AW +: AW];
    localparam logic [AW-1:0] ZL = ZONE_LIMIT[z*AW +: AW];
    assign rdZone[z] = protEnR[z] && (rdAddr >= ZB) && (rdAddr <= ZL);
    assign wrZone[z] = protEnR[z] && (wrAddr >= ZB) && (wrAddr <= ZL);
  end

  always_comb begin
    flags.rdFrame   = (rdAddr >= FRAME_BASE) && (rdAddr <= FRAME_LIMIT);
    flags.wrFrame   = (wrAddr >= FRAME_BASE) && (wrAddr <= FRAME_LIMIT);
    flags.rdProt    = |rdZone;
    flags.wrProt    = |wrZone;
    flags.pendProt  = pendProtR;
    flags.pendHitRd = (pendAddr == rdAddr);
    flags.wrHitRd   = (wrAddr == rdAddr);
  end

  assign protEn   = protEnR;
  assign busAddr  = strobe.selRd ? rdAddr : pendAddr;
  assign busWData = pendData;
endmodule

// File: rtl/wro_ctrl.sv
module wro_ctrl
  import wro_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrValid,
  input  logic       wrProg,
  input  logic       rdValid,
  input  logic       rdProg,
  input  logic       busReady,
  input  dpFlags_t   flags,
  output ctlStrobe_t strobe,
  output logic       busValid,
  output logic       busWrite,
  output logic       stall,
  output logic       pendV
);
  logic wrTaken;
  logic wrLive, rdLive, wrNew;
  logic pendConf, newConf, rdGo, drain, capWr;

  always_comb begin
    wrLive   = wrValid && !(wrProg && flags.wrFrame);
    rdLive   = rdValid && !(rdProg && flags.rdFrame);
    wrNew    = wrLive && !wrTaken;
    pendConf = pendV && (flags.rdProt || flags.pendProt || flags.pendHitRd);
    newConf  = wrNew && (flags.rdProt || flags.wrProt || flags.wrHitRd);
    rdGo     = rdLive && !pendConf && !newConf;
    drain    = pendV && !rdGo && busReady;
    capWr    = wrNew && (!pendV || drain);
    stall    = (rdLive && !(rdGo && busReady)) || (wrNew && !capWr);
    busValid = rdGo || pendV;
    busWrite = pendV && !rdGo;
    strobe.capWr = capWr;
    strobe.selRd = rdGo;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendV   <= 1'b0;
      wrTaken <= 1'b0;
    end else begin
      if (capWr) pendV <= 1'b1;
      else if (drain) pendV <= 1'b0;
      wrTaken <= stall ? (wrTaken || capWr) : 1'b0;
    end
  end
endmodule

// File: rtl/wro_top.sv
module wro_top
  import wro_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int NZONE = 2,
  parameter logic [AW-1:0] FRAME_BASE = 16'h0800,
  parameter logic [AW-1:0] FRAME_LIMIT = 16'h7FFF,
  parameter logic [NZONE*AW-1:0] ZONE_BASE = {16'h7000, 16'h6000},
  parameter logic [NZONE*AW-1:0] ZONE_LIMIT = {16'h7FFF, 16'h6FFF}
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [NZONE-1:0] cfgProt,
  input  logic             wrValid,
  input  logic [AW-1:0]    wrAddr,
  input  logic [DW-1:0]    wrData,
  input  logic             wrProg,
  input  logic             rdValid,
  input  logic [AW-1:0]    rdAddr,
  input  logic             rdProg,
  input  logic             busReady,
  output logic             busValid,
  output logic             busWrite,
  output logic [AW-1:0]    busAddr,
  output logic [DW-1:0]    busWData,
  output logic             stall
);
  ctlStrobe_t       strobe;
  dpFlags_t         flags;
  logic [NZONE-1:0] protEn;
  logic             pendV;

  wro_datapath #(
    .AW(AW), .DW(DW), .NZONE(NZONE),
    .FRAME_BASE(FRAME_BASE), .FRAME_LIMIT(FRAME_LIMIT),
    .ZONE_BASE(ZONE_BASE), .ZONE_LIMIT(ZONE_LIMIT)
  ) dp_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgProt(cfgProt),
    .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr),
    .strobe(strobe), .flags(flags), .protEn(protEn),
    .busAddr(busAddr), .busWData(busWData)
  );

  wro_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrProg(wrProg),
    .rdValid(rdValid), .rdProg(rdProg), .busReady(busReady),
    .flags(flags), .strobe(strobe), .busValid(busValid),
    .busWrite(busWrite), .stall(stall), .pendV(pendV)
  );
endmodule

// File: rtl/wro_checker.sv
module wro_checker #(
  parameter int AW = 16,
  parameter int NZONE = 2,
  parameter logic [AW-1:0] FRAME_BASE = 16'h0800,
  parameter logic [AW-1:0] FRAME_LIMIT = 16'h7FFF,
  parameter logic [NZONE*AW-1:0] ZONE_BASE = {16'h7000, 16'h6000},
  parameter logic [NZONE*AW-1:0] ZONE_LIMIT = {16'h7FFF, 16'h6FFF}
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrValid,
  input logic             rdValid,
  input logic [AW-1:0]    rdAddr,
  input logic             rdProg,
  input logic             busReady,
  input logic             busValid,
  input logic             busWrite,
  input logic [AW-1:0]    busAddr,
  input logic             stall,
  input logic             pendV,
  input logic [NZONE-1:0] protEn
);
  logic busInZone;
  logic rdInFrame;

  always_comb begin
    busInZone = 1'b0;
    for (int z = 0; z < NZONE; z++)
      if (protEn[z] && busAddr >= ZONE_BASE[z*AW +: AW] && busAddr <= ZONE_LIMIT[z*AW +: AW])
        busInZone = 1'b1;
    rdInFrame = (rdAddr >= FRAME_BASE) && (rdAddr <= FRAME_LIMIT);
  end

  a_r4_prot_read_after_write: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite && busInZone) |-> !pendV);

  a_r2_write_from_buffer: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite) |-> pendV);

  a_r3_taken_read_on_bus: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !rdProg && !stall) |-> (busValid && !busWrite && busReady && busAddr == rdAddr));

  a_r6_prog_frame_dropped: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && rdProg && rdInFrame) |-> !(busValid && !busWrite));

  a_r8_write_stall_needs_full: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !rdValid && stall) |-> pendV);
endmodule

bind wro_top wro_checker #(
  .AW(AW), .NZONE(NZONE), .FRAME_BASE(FRAME_BASE), .FRAME_LIMIT(FRAME_LIMIT),
  .ZONE_BASE(ZONE_BASE), .ZONE_LIMIT(ZONE_LIMIT)
) chk_i (
  .clk(clk), .rstN(rstN), .wrValid(wrValid), .rdValid(rdValid),
  .rdAddr(rdAddr), .rdProg(rdProg), .busReady(busReady),
  .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
  .stall(stall), .pendV(pendV), .protEn(protEn)
);

// File: tb/wro_top_tb_top.sv
module wro_top_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [1:0] cfgProt = '0;
  logic wrValid = 1'b0, wrProg = 1'b0, rdValid = 1'b0, rdProg = 1'b0;
  logic [15:0] wrAddr = '0, wrData = '0, rdAddr = '0;
  logic busReady = 1'b1;
  logic busValid, busWrite, stall;
  logic [15:0] busAddr, busWData;

  int checks = 0;
  int fails = 0;
  logic [32:0] expQ[$];

  always #2 clk = ~clk;

  wro_top dut_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgProt(cfgProt),
    .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData), .wrProg(wrProg),
    .rdValid(rdValid), .rdAddr(rdAddr), .rdProg(rdProg),
    .busReady(busReady), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWData(busWData), .stall(stall)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pop one expected bus item per accepted request
  always @(negedge clk) begin
    if (rstN && busValid && busReady) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R6 unexpected bus request", {busWrite, busAddr}, 0);
      end else begin
        logic [32:0] e;
        e = expQ.pop_front();
        if (e[32])
          check(busWrite && busAddr == e[31:16] && busWData == e[15:0], "R2 bus write order",
                {busWrite, busAddr, busWData}, e);
        else
          check(!busWrite && busAddr == e[31:16], "R3 bus read order",
                {busWrite, busAddr}, {1'b0, e[31:16]});
      end
    end
  end

  task automatic expW(input logic [15:0] a, input logic [15:0] d); expQ.push_back({1'b1, a, d}); endtask
  task automatic expR(input logic [15:0] a); expQ.push_back({1'b0, a, 16'h0}); endtask

  task automatic idle();
    @(posedge clk); #1;
    wrValid = 0; rdValid = 0; wrProg = 0; rdProg = 0;
  endtask

  // present requests, hold while stalled, return number of stall cycles
  task automatic doTxn(input bit wv, input logic [15:0] wa, input logic [15:0] wd, input bit wp,
                       input bit rv, input logic [15:0] ra, input bit rp, output int nStall);
    nStall = 0;
    @(posedge clk); #1;
    wrValid = wv; wrAddr = wa; wrData = wd; wrProg = wp;
    rdValid = rv; rdAddr = ra; rdProg = rp;
    forever begin
      @(negedge clk);
      if (!stall) break;
      nStall++;
      if (nStall > 20) break;
      @(posedge clk); #1;
    end
  endtask

  task automatic drainIdle();
    repeat (3) idle();
    check(expQ.size() == 0, "R2 all expected bus items seen", expQ.size(), 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!stall && !busValid, "R1 outputs idle in reset", {stall, busValid}, 0);
    @(posedge clk); #1 rstN = 1'b1;
    @(negedge clk);
    check(!stall && !busValid, "R1 outputs idle after reset", {stall, busValid}, 0);

    // R3: write and plain read together, read overtakes
    expR(16'h2000); expW(16'h1000, 16'hAAAA);
    doTxn(1, 16'h1000, 16'hAAAA, 0, 1, 16'h2000, 0, n);
    check(n == 0, "R3 overtaking read no stall", n, 0);
    drainIdle();

    // R4 + R1: pending write in zone 0 (enabled by reset), then plain read
    expW(16'h6010, 16'h1234); expR(16'h2000);
    doTxn(1, 16'h6010, 16'h1234, 0, 0, 16'h0, 0, n);
    check(n == 0, "R4 write taken", n, 0);
    doTxn(0, 16'h0, 16'h0, 0, 1, 16'h2000, 0, n);
    check(n == 1, "R4/R1 pending protected write one stall", n, 1);
    drainIdle();

    // R4: write and protected read in same cycle
    expW(16'h1000, 16'h0055); expR(16'h7004);
    doTxn(1, 16'h1000, 16'h0055, 0, 1, 16'h7004, 0, n);
    check(n == 2, "R4 same-cycle protected read two stalls", n, 2);
    drainIdle();

    // R5: same-address read held; different address overtakes
    expW(16'h3000, 16'h0005); expR(16'h3000);
    doTxn(1, 16'h3000, 16'h0005, 0, 0, 16'h0, 0, n);
    doTxn(0, 16'h0, 16'h0, 0, 1, 16'h3000, 0, n);
    check(n == 1, "R5 same address read held", n, 1);
    drainIdle();
    expR(16'h3002); expW(16'h3000, 16'h0006);
    doTxn(1, 16'h3000, 16'h0006, 0, 0, 16'h0, 0, n);
    doTxn(0, 16'h0, 16'h0, 0, 1, 16'h3002, 0, n);
    check(n == 0, "R5 other address not held", n, 0);
    drainIdle();

    // R7: disable zone 1, protected-looking read now overtakes
    @(posedge clk); #1 cfgWe = 1; cfgProt = 2'b01;
    @(posedge clk); #1 cfgWe = 0;
    expR(16'h7002); expW(16'h7000, 16'h0077);
    doTxn(1, 16'h7000, 16'h0077, 0, 0, 16'h0, 0, n);
    doTxn(0, 16'h0, 16'h0, 0, 1, 16'h7002, 0, n);
    check(n == 0, "R7 disabled zone no stall", n, 0);
    drainIdle();
    @(posedge clk); #1 cfgWe = 1; cfgProt = 2'b11;
    @(posedge clk); #1 cfgWe = 0;
    expW(16'h7000, 16'h0078); expR(16'h7002);
    doTxn(1, 16'h7000, 16'h0078, 0, 0, 16'h0, 0, n);
    doTxn(0, 16'h0, 16'h0, 0, 1, 16'h7002, 0, n);
    check(n == 1, "R7 re-enabled zone holds read", n, 1);
    drainIdle();

    // R6: program-space accesses to peripheral range are dropped
    doTxn(0, 16'h0, 16'h0, 0, 1, 16'h6000, 1, n);
    check(n == 0 && !busValid, "R6 prog read dropped", {n[3:0], busValid}, 0);
    doTxn(1, 16'h7000, 16'h0099, 1, 0, 16'h0, 0, n);
    check(n == 0, "R6 prog write no stall", n, 0);
    idle();
    @(negedge clk);
    check(!busValid, "R6 prog write not forwarded", busValid, 0);
    expR(16'h9000);
    doTxn(0, 16'h0, 16'h0, 0, 1, 16'h9000, 1, n);
    check(n == 0, "R6 prog read outside range forwarded", n, 0);
    drainIdle();

    // R8 + R2: buffer full while bus not ready
    expW(16'h1000, 16'h0101); expW(16'h1002, 16'h0202);
    @(posedge clk); #1 busReady = 0;
    doTxn(1, 16'h1000, 16'h0101, 0, 0, 16'h0, 0, n);
    check(n == 0, "R8 first write taken", n, 0);
    @(posedge clk); #1 wrAddr = 16'h1002; wrData = 16'h0202;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(stall, "R8 stall while buffer full", stall, 1);
      check(busValid && busWrite && busAddr == 16'h1000, "R2 write held on bus", busAddr, 16'h1000);
      if (i < 2) @(posedge clk);
    end
    @(posedge clk); #1 busReady = 1;
    @(negedge clk);
    check(!stall, "R8 stall released on drain", stall, 0);
    drainIdle();

    // R9: protected read not accepted keeps stall high
    expR(16'h6000);
    @(posedge clk); #1 busReady = 0;
    rdValid = 1; rdAddr = 16'h6000; rdProg = 0;
    @(negedge clk);
    check(stall && busValid && !busWrite, "R9 stall while read waits", stall, 1);
    @(posedge clk); #1 busReady = 1;
    @(negedge clk);
    check(!stall, "R9 stall drops on accept", stall, 0);
    drainIdle();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule